// File: doc/BRIEF.md
# CAN Identifier Acceptance Unit

This block decides whether a received CAN frame is kept. Once the frame's identifier is complete and a one-cycle strobe marks it as valid, the block checks the identifier against six programmable acceptance filters. Each filter holds a 29-bit identifier pattern and a frame-type bit. Two masks select which identifier bits take part in the check. A mask bit of 0 makes that bit a don't-care. A mask bit of 1 requires the identifier bit to equal the filter bit.

The lower filter group (filters 0 and 1) uses mask 0. The upper group (filters 2 to 5) uses mask 1. In legacy mode the group that holds the hitting filter also selects the receive buffer: buffer 0 for the lower group and buffer 1 for the upper group. In FIFO mode the filter-to-buffer link is dropped. Any enabled filter that matches sends the frame to the next FIFO slot. When several filters match, the lowest-numbered one is reported. The decision is registered and shown as a one-cycle pulse in the cycle after the strobe.

A two-state machine produces the pulse. `S_WAIT` means no decision is being presented. `S_HIT` means an accepted decision is on the outputs for this cycle. The transitions are:
- `S_WAIT`→`S_HIT` on a strobe with at least one hit.
- `S_HIT`→`S_HIT` on a further strobe with a hit in the very next cycle.
- `S_HIT`→`S_WAIT` when no hitting strobe follows.
- `S_WAIT`→`S_WAIT` otherwise.

Top module: `can_accept_unit`

## Requirements
- R1: While reset is held and after it is released with no strobe, `acc_pulse` is 0, `acc_dest` is 0 and `acc_filt` is 0.
- R2: A strobe on `msg_valid` sampled at clock edge k gives its decision on `acc_pulse` in the cycle after edge k. That pulse lasts exactly one cycle. With `msg_valid` low, no pulse appears, whatever the identifier.
- R3: An identifier bit whose mask bit is 0 does not affect whether a filter matches.
- R4: An identifier bit whose mask bit is 1 must equal the filter's bit at that position, or that filter does not match.
- R5: A filter matches only when its frame-type bit `filt_ext[i]` equals `msg_ext`. This holds whatever the masks are.
- R6: A filter whose `filt_en[i]` bit is 0 never matches.
- R7: In legacy mode (`fifo_mode`=0), a hit on filter 0 or 1, checked under `mask0`, gives `acc_dest`=2'b00 (receive buffer 0).
- R8: In legacy mode, a hit on filters 2 to 5, checked under `mask1`, gives `acc_dest`=2'b01 (receive buffer 1).
- R9: In FIFO mode (`fifo_mode`=1), a hit on any enabled filter gives `acc_dest`=2'b10 (next FIFO slot). Each filter keeps its own mask.
- R10: When several filters match, `acc_filt` carries the lowest matching index (0 to 5). In legacy mode that filter's group sets the buffer.
- R11: A strobe that no filter matches gives no pulse. Outside a pulse, `acc_dest` and `acc_filt` read 0.
- R12: Strobes in consecutive cycles give independent decisions in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | One-cycle strobe: identifier is complete |
| msg_id | input | 29 | Received identifier |
| msg_ext | input | 1 | Received frame type (1 = extended) |
| fifo_mode | input | 1 | 0 = legacy routing, 1 = FIFO routing |
| filt_en | input | 6 | Per-filter enable |
| filt_id | input | 174 | Filter patterns; filter i at bits [29*i +: 29] |
| filt_ext | input | 6 | Per-filter required frame type |
| mask0 | input | 29 | Mask for filters 0 and 1 |
| mask1 | input | 29 | Mask for filters 2 to 5 |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_dest | output | 2 | 00 buffer 0, 01 buffer 1, 10 FIFO |
| acc_filt | output | 3 | Index of the reporting filter |

## Verification
Two functions can fall in the same cycle. The first is presenting the previous frame's decision, where the machine sits in `S_HIT`. The second is sampling a new strobe, which may keep the machine in `S_HIT` with fresh values. The bench provokes this with strobes on adjacent clocks whose hits, modes and buffers differ. Its scoreboard expects one decision per strobe, each in its own cycle with its own index and destination. A third strobe that nothing matches must end the pulse train at once. Priority collisions, where two filters hit in one evaluation, are judged the same way against the lowest matching index.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    typedef enum logic [1:0] {
        DST_RXB0 = 2'b00,
        DST_RXB1 = 2'b01,
        DST_FIFO = 2'b10
    } dest_e;

    typedef enum logic {
        S_WAIT = 1'b0,
        S_HIT  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/acc_filter_cmp.sv
module acc_filter_cmp #(
    parameter int ID_W = 29
) (
    input  logic [ID_W-1:0] id,
    input  logic            id_ext,
    input  logic [ID_W-1:0] pattern,
    input  logic            pattern_ext,
    input  logic [ID_W-1:0] mask,
    input  logic            enable,
    output logic            hit
);

    logic [ID_W-1:0] care_diff;

    always_comb begin
        care_diff = (id ^ pattern) & mask;
        hit       = enable && (id_ext == pattern_ext) && (care_diff == '0);
    end

endmodule

// File: rtl/acc_prio_enc.sv
module acc_prio_enc #(
    parameter int N  = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    // R10: the granted index is requesting and no lower index is
    always_comb begin
        if (any) begin
            p_grant_requests_r10: assert (req[idx])
                else $error("grant points at idle request");
            for (int j = 0; j < N; j++) begin
                if (j < int'(idx)) begin
                    p_lowest_wins_r10: assert (!req[j])
                        else $error("lower request skipped");
                end
            end
        end
    end

endmodule

// File: rtl/can_accept_unit.sv
module can_accept_unit #(
    parameter int ID_W     = 29,
    parameter int NUM_FILT = 6,
    parameter int GRP0_N   = 2,
    localparam int FW      = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msg_valid,
    input  logic [ID_W-1:0]          msg_id,
    input  logic                     msg_ext,
    input  logic                     fifo_mode,
    input  logic [NUM_FILT-1:0]      filt_en,
    input  logic [NUM_FILT*ID_W-1:0] filt_id,
    input  logic [NUM_FILT-1:0]      filt_ext,
    input  logic [ID_W-1:0]          mask0,
    input  logic [ID_W-1:0]          mask1,
    output logic                     acc_pulse,
    output logic [1:0]               acc_dest,
    output logic [FW-1:0]            acc_filt
);
    import can_acc_pkg::*;

    logic [NUM_FILT-1:0] hit_vec;
    logic                hit_any;
    logic [FW-1:0]       hit_idx;
    dest_e               dest_d;
    dest_e               dest_q;
    logic [FW-1:0]       idx_q;
    acc_state_e          state_q;
    acc_state_e          state_d;

    // One comparator per filter; the group picks the mask
    for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
        logic [ID_W-1:0] sel_mask;
        assign sel_mask = (i < GRP0_N) ? mask0 : mask1;
        acc_filter_cmp #(.ID_W(ID_W)) u_cmp (
            .id          (msg_id),
            .id_ext      (msg_ext),
            .pattern     (filt_id[i*ID_W +: ID_W]),
            .pattern_ext (filt_ext[i]),
            .mask        (sel_mask),
            .enable      (filt_en[i]),
            .hit         (hit_vec[i])
        );
    end

    acc_prio_enc #(.N(NUM_FILT)) u_prio (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    always_comb begin
        if (fifo_mode)                  dest_d = DST_FIFO;
        else if (int'(hit_idx) < GRP0_N) dest_d = DST_RXB0;
        else                            dest_d = DST_RXB1;
    end

    // Next-state logic
    always_comb begin
        state_d = S_WAIT;
        unique case (state_q)
            S_WAIT: state_d = (msg_valid && hit_any) ? S_HIT : S_WAIT;
            S_HIT:  state_d = (msg_valid && hit_any) ? S_HIT : S_WAIT;
        endcase
    end

    // State and captured decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT;
            dest_q  <= DST_RXB0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (msg_valid && hit_any) begin
                dest_q <= dest_d;
                idx_q  <= hit_idx;
            end
        end
    end

    // Outputs
    always_comb begin
        acc_pulse = 1'b0;
        acc_dest  = 2'b00;
        acc_filt  = '0;
        unique case (state_q)
            S_WAIT: ;
            S_HIT: begin
                acc_pulse = 1'b1;
                acc_dest  = dest_q;
                acc_filt  = idx_q;
            end
        endcase
    end

    // R2: a pulse always follows a strobe
    p_pulse_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> $past(msg_valid));

    // R2: no strobe means no pulse next cycle
    p_quiet_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !acc_pulse);

    // R9: FIFO destination tracks the mode at strobe time
    p_fifo_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> ((acc_dest == 2'b10) == $past(fifo_mode)));

    // R7: buffer 0 only from the lower filter group
    p_buf0_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && acc_dest == 2'b00) |-> (int'(acc_filt) < GRP0_N));

    // R8: buffer 1 only from the upper filter group
    p_buf1_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_pulse && acc_dest == 2'b01) |-> (int'(acc_filt) >= GRP0_N));

    // R6: the reported filter was enabled at strobe time
    p_enabled_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> (($past(filt_en) >> acc_filt) & 1) != 0);

endmodule

// File: tb/sim_can_accept_unit.sv
module sim_can_accept_unit;

    localparam int IDW = 29;
    localparam int NF  = 6;

    typedef struct {
        logic       pulse;
        logic [1:0] dest;
        logic [2:0] filt;
        string      tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                msg_valid = 1'b0;
    logic [IDW-1:0]      msg_id = '0;
    logic                msg_ext = 1'b0;
    logic                fifo_mode = 1'b0;
    logic [NF-1:0]       filt_en = '0;
    logic [NF*IDW-1:0]   filt_id = '0;
    logic [NF-1:0]       filt_ext = '0;
    logic [IDW-1:0]      mask0 = '0;
    logic [IDW-1:0]      mask1 = '0;
    logic                acc_pulse;
    logic [1:0]          acc_dest;
    logic [2:0]          acc_filt;

    // configuration shadow, applied at the next driven edge
    logic                c_fifo = 1'b0;
    logic [NF-1:0]       c_en = '0;
    logic [IDW-1:0]      c_pat [NF];
    logic [NF-1:0]       c_ext = '0;
    logic [IDW-1:0]      c_m0 = '0;
    logic [IDW-1:0]      c_m1 = '0;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t sb [$];

    always #5 clk = ~clk;

    can_accept_unit u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
        .msg_ext(msg_ext), .fifo_mode(fifo_mode), .filt_en(filt_en),
        .filt_id(filt_id), .filt_ext(filt_ext), .mask0(mask0), .mask1(mask1),
        .acc_pulse(acc_pulse), .acc_dest(acc_dest), .acc_filt(acc_filt)
    );

    function automatic exp_t model(input logic v, input logic [IDW-1:0] id,
                                   input logic ext, input string tag);
        exp_t e;
        e.pulse = 1'b0; e.dest = 2'b00; e.filt = 3'd0; e.tag = tag;
        if (v) begin
            for (int i = 0; i < NF; i++) begin
                logic [IDW-1:0] m;
                m = (i < 2) ? c_m0 : c_m1;
                if (!e.pulse && c_en[i] && c_ext[i] == ext &&
                    ((id ^ c_pat[i]) & m) == '0) begin
                    e.pulse = 1'b1;
                    e.filt  = 3'(i);
                    e.dest  = c_fifo ? 2'b10 : ((i < 2) ? 2'b00 : 2'b01);
                end
            end
        end
        return e;
    endfunction

    task automatic drive(input logic v, input logic [IDW-1:0] id,
                         input logic ext, input string tag);
        @(negedge clk);
        msg_valid = v;
        msg_id    = id;
        msg_ext   = ext;
        fifo_mode = c_fifo;
        filt_en   = c_en;
        filt_ext  = c_ext;
        mask0     = c_m0;
        mask1     = c_m1;
        for (int i = 0; i < NF; i++) filt_id[i*IDW +: IDW] = c_pat[i];
        sb.push_back(model(v, id, ext, tag));
    endtask

    task automatic check_now(input logic p, input logic [1:0] d,
                             input logic [2:0] f, input string tag);
        n_checks++;
        if (acc_pulse !== p || acc_dest !== d || acc_filt !== f) begin
            n_fail++;
            $display("FAIL %s: got pulse=%0b dest=%0d filt=%0d, expected pulse=%0b dest=%0d filt=%0d",
                     tag, acc_pulse, acc_dest, acc_filt, p, d, f);
        end
    endtask

    // monitor: one decision per driven cycle, read 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check_now(e.pulse, e.dest, e.filt, e.tag);
            end
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) c_pat[i] = '0;
        repeat (3) @(negedge clk);
        check_now(1'b0, 2'b00, 3'd0, "R1 in reset");
        rst_n = 1'b1;
        drive(1'b0, '0, 1'b0, "R1 after reset");

        // all filters off: nothing accepted
        c_m0 = '1; c_m1 = '1; c_ext = '1;
        drive(1'b1, '0, 1'b1, "R6 all disabled");

        // filter 0, full mask, legacy
        c_en = 6'b000001; c_pat[0] = 29'h0ABC_1234;
        drive(1'b1, 29'h0ABC_1234, 1'b1, "R7 exact match f0");
        drive(1'b1, 29'h0ABC_1235, 1'b1, "R4 masked bit differs");
        c_m0 = ~29'h1;
        drive(1'b1, 29'h0ABC_1235, 1'b1, "R3 unmasked bit differs");
        drive(1'b1, 29'h0ABC_1234, 1'b0, "R5 frame type mismatch");
        c_m0 = '0;
        drive(1'b1, 29'h1FFF_FFFF, 1'b0, "R5 zero mask still checks type");
        drive(1'b1, 29'h1FFF_FFFF, 1'b1, "R3 zero mask accepts any id");

        // upper group
        c_m0 = '1; c_en = 6'b001000; c_pat[3] = 29'h0000_0777;
        drive(1'b1, 29'h0000_0777, 1'b1, "R8 f3 to buffer 1");
        drive(1'b1, 29'h0000_0776, 1'b1, "R11 no match");

        // priority
        c_en = 6'b001010; c_pat[1] = 29'h0000_0777;
        drive(1'b1, 29'h0000_0777, 1'b1, "R10 f1 over f3");
        c_en = 6'b010100; c_pat[2] = 29'h0155_0000; c_pat[4] = 29'h0155_0000;
        drive(1'b1, 29'h0155_0000, 1'b1, "R10 f2 over f4");

        // FIFO routing
        c_fifo = 1'b1; c_en = 6'b010000;
        drive(1'b1, 29'h0155_0000, 1'b1, "R9 f4 to fifo");
        c_en = 6'b000010;
        drive(1'b1, 29'h0000_0777, 1'b1, "R9 f1 to fifo");
        c_en = 6'b100000; c_pat[5] = 29'h0155_0000; c_pat[4] = 29'h0155_0000;
        drive(1'b1, 29'h0155_0000, 1'b1, "R6 disabled f4 skipped");

        // no strobe: identifier matches but nothing happens
        drive(1'b0, 29'h0155_0000, 1'b1, "R2 no strobe no pulse");

        // back to back strobes with differing outcome
        c_fifo = 1'b0; c_en = 6'b101010;
        drive(1'b1, 29'h0155_0000, 1'b1, "R12 first of pair f5");
        drive(1'b1, 29'h0000_0777, 1'b1, "R12 second of pair f1");
        c_fifo = 1'b1;
        drive(1'b1, 29'h0000_0777, 1'b1, "R12 third fifo f1");
        drive(1'b1, 29'h0000_0000, 1'b1, "R2 pulse ends on miss");
        drive(1'b0, 29'h0000_0000, 1'b1, "R2 idle");
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule